// File: doc/BRIEF.md
# Walking-Address Memory Test Sequencer

This block runs a fixed functional test on an external 256-word by 4-bit static memory that has two chip selects: one active high and one active low. After a one-cycle `start` pulse it drives the memory's address, write data, both selects, write enable and output enable. It works through a list of fixed-length vectors. At a sampling point inside each read vector it compares the memory's output bus and its driven flag against an expected value that it generates itself.

The test has three walking-address phases, then one test for each chip select, then an output-enable test. The walking phases use address zero and the eight one-hot addresses. A fill pass writes the first pattern. An interleaved pass reads the first pattern back and overwrites it with the second. A verify pass reads the second pattern. Each select test and the output-enable test then show that a write made with the memory deselected does not land, and that a disabled output is not driven.

A run ends with `done`. If the run failed, `fail` is also high, and the failing step number, the expected value and the observed value are held on outputs until the next start. Vector length and sampling point are set in nanoseconds and converted to clock counts.

Top module: `mt_seq`

## Requirements
- R1: After reset `busy`, `done` and `fail` are low. While idle the memory is parked with both selects inactive (`mem_sel_hi`=0, `mem_sel_lo_n`=1) and `mem_we_n`=1, `mem_oe_n`=1.
- R2: A `start` pulse while idle begins a run on the next clock with `busy` high. A passing run lasts exactly 129 vectors and then raises `done` with `fail` low. A `start` pulse during a run has no effect on its length or outcome.
- R3: Each vector lasts CYCLE_NS/CLK_NS clocks, which is 100 clocks at 5 ns and 500 ns. A read is compared at the clock edge SAMPLE_NS/CLK_NS clocks after its vector begins, which is 80 clocks.
- R4: Steps are numbered from 0 in this order:
  - step 0 sets the initial state: address 0, `mem_sel_hi`=1, `mem_sel_lo_n`=0, `mem_we_n`=1, `mem_oe_n`=0, data 0.
  - fill uses steps 1–27.
  - interleave uses steps 28–72.
  - verify uses steps 73–90.
  - the low-select test uses steps 91–103.
  - the high-select test uses steps 104–116.
  - the output-enable test uses steps 117–128.
  
  The walking addresses come in the order 0, 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80.
- R5: Each write takes three vectors: the address with `mem_we_n`=1, then `mem_we_n`=0 with the data, then `mem_we_n`=1. Fill address i uses steps 1+3i to 3+3i and writes 0101 (bit 0 set).
- R6: Interleave address i (base 28+5i) reads at step 29+5i expecting 0101, then writes 1010 in vectors +2 to +4. A memory that ignores address bit k fails at step 29+5(k+1), expecting 0101 and observing 1010.
- R7: Verify address i reads at step 74+2i expecting 1010.
- R8: The low-select test writes 0000 to address 0 and reads it back at step 96. It deselects with `mem_sel_lo_n`=1 during steps 97–100 and attempts to write 1111 at step 99. It reselects and expects 0000 at step 103.
- R9: The high-select test follows the same order with `mem_sel_hi`=0 during steps 110–113. Its checks are at steps 109 and 116.
- R10: The output-enable test writes and reads 0000, with the check at step 122. It then holds `mem_oe_n`=1 from step 123 on, writes 0000, and at step 128 expects the memory output not to be driven.
- R11: On the first mismatch the sequencer stops at that sample edge. `busy` drops and `done` and `fail` rise. `fail_step`, `fail_exp`, `fail_exp_en`, `fail_obs` and `fail_obs_en` hold the step number and the expected and observed data and driven flags until the next start.
- R12: A `start` after a failed run clears `fail` and runs the whole test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| mem_dout | input | 4 | Memory read data |
| mem_dout_en | input | 1 | Memory is driving `mem_dout` |
| mem_addr | output | 8 | Memory address |
| mem_din | output | 4 | Memory write data |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_sel_lo_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| fail | output | 1 | Last run ended on a mismatch |
| fail_step | output | 8 | Step number of the mismatch |
| fail_exp | output | 4 | Expected data at the mismatch |
| fail_exp_en | output | 1 | Expected driven flag |
| fail_obs | output | 4 | Observed data at the mismatch |
| fail_obs_en | output | 1 | Observed driven flag |

## Verification
The hardest branches to reach are the ones where a blocked write lands, or a disabled output drives, and so produces a mismatch. A correct memory never produces either. The bench therefore models the memory itself and injects one fault per run:
- a dropped address bit
- a stuck data bit
- an ignored low select
- an ignored high select
- an ignored output enable

For each fault the bench derives the expected failing step, the expected and observed values, and the exact clock of `done` from the step numbering in the requirements.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int SUB_W = 4;

    typedef enum logic [2:0] {
        PH_INIT, PH_FILL, PH_SWAP, PH_VERIFY, PH_SEL_LO, PH_SEL_HI, PH_OE
    } phase_e;

    typedef struct packed {
        logic sel_hi;
        logic sel_lo_n;
        logic we_n;
        logic oe_n;
        logic chk;
        logic exp_drv;
    } ctl_t;

    function automatic int vecs_in(phase_e p);
        case (p)
            PH_FILL:   return 3;
            PH_SWAP:   return 5;
            PH_VERIFY: return 2;
            PH_SEL_LO: return 13;
            PH_SEL_HI: return 13;
            PH_OE:     return 12;
            default:   return 1;
        endcase
    endfunction

    function automatic logic is_walk(phase_e p);
        return (p == PH_FILL) || (p == PH_SWAP) || (p == PH_VERIFY);
    endfunction

endpackage

// File: rtl/mt_vec_timer.sv
module mt_vec_timer #(
    parameter int CYC_CLKS = 100,
    parameter int SMP_CLKS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic smp,
    output logic last
);
    localparam int CNT_W = $clog2(CYC_CLKS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        smp  = run && (cnt_q == CNT_W'(SMP_CLKS - 1));
        last = run && (cnt_q == CNT_W'(CYC_CLKS - 1));
        if (!run || last) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the vector counter never passes the vector length
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYC_CLKS - 1));
    // R3: an idle sequencer holds the counter at zero
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/mt_vec_decode.sv
module mt_vec_decode
    import mt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4,
    parameter int ITEM_W = 4
) (
    input  phase_e             phase,
    input  logic [ITEM_W-1:0]  item,
    input  logic [SUB_W-1:0]   sub,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  exp,
    output ctl_t               ctl
);
    function automatic logic [DATA_W-1:0] pat_a();
        logic [DATA_W-1:0] p;
        for (int i = 0; i < DATA_W; i++) p[i] = (i % 2 == 0);
        return p;
    endfunction

    localparam logic [DATA_W-1:0] PAT_A   = pat_a();
    localparam logic [DATA_W-1:0] PAT_B   = ~PAT_A;
    localparam logic [DATA_W-1:0] PAT_BLK = '1;

    logic [ADDR_W-1:0] walk_addr;

    always_comb begin
        walk_addr = (item == '0) ? '0 : (ADDR_W'(1) << (item - ITEM_W'(1)));
        addr = is_walk(phase) ? walk_addr : '0;
        din  = '0;
        exp  = '0;
        ctl  = '{sel_hi: 1'b1, sel_lo_n: 1'b0, we_n: 1'b1, oe_n: 1'b0,
                 chk: 1'b0, exp_drv: 1'b1};
        case (phase)
            PH_FILL: begin
                if (sub == 4'd1) begin ctl.we_n = 1'b0; din = PAT_A; end
            end
            PH_SWAP: begin
                if (sub == 4'd1) begin ctl.chk = 1'b1; exp = PAT_A; end
                if (sub == 4'd3) begin ctl.we_n = 1'b0; din = PAT_B; end
            end
            PH_VERIFY: begin
                if (sub == 4'd1) begin ctl.chk = 1'b1; exp = PAT_B; end
            end
            PH_SEL_LO, PH_SEL_HI: begin
                if (sub >= 4'd6 && sub <= 4'd9) begin
                    if (phase == PH_SEL_LO) ctl.sel_lo_n = 1'b1;
                    else                    ctl.sel_hi   = 1'b0;
                end
                if (sub == 4'd2) ctl.we_n = 1'b0;
                if (sub == 4'd8) begin ctl.we_n = 1'b0; din = PAT_BLK; end
                if (sub == 4'd5 || sub == 4'd12) ctl.chk = 1'b1;
            end
            PH_OE: begin
                if (sub >= 4'd6) ctl.oe_n = 1'b1;
                if (sub == 4'd2 || sub == 4'd8) ctl.we_n = 1'b0;
                if (sub == 4'd5) ctl.chk = 1'b1;
                if (sub == 4'd11) begin ctl.chk = 1'b1; ctl.exp_drv = 1'b0; end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mt_rd_cmp.sv
module mt_rd_cmp #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] exp,
    input  logic              exp_drv,
    input  logic [DATA_W-1:0] obs,
    input  logic              obs_drv,
    output logic              miss
);
    always_comb begin
        if (exp_drv) miss = !obs_drv || (obs != exp);
        else         miss = obs_drv;
    end
endmodule

// File: rtl/mt_seq.sv
module mt_seq
    import mt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 4,
    parameter int CLK_NS    = 5,
    parameter int CYCLE_NS  = 500,
    parameter int SAMPLE_NS = 400,
    localparam int N_ADDR   = ADDR_W + 1,
    localparam int N_STEPS  = 1 + 10 * N_ADDR + 38,
    localparam int STEP_W   = $clog2(N_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] mem_dout,
    input  logic              mem_dout_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_din,
    output logic              mem_sel_hi,
    output logic              mem_sel_lo_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [STEP_W-1:0] fail_step,
    output logic [DATA_W-1:0] fail_exp,
    output logic              fail_exp_en,
    output logic [DATA_W-1:0] fail_obs,
    output logic              fail_obs_en
);
    localparam int CYC_CLKS = CYCLE_NS / CLK_NS;
    localparam int SMP_CLKS = SAMPLE_NS / CLK_NS;
    localparam int ITEM_W   = $clog2(N_ADDR);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              fail;
        phase_e            phase;
        logic [ITEM_W-1:0] item;
        logic [SUB_W-1:0]  sub;
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] f_step;
        logic [DATA_W-1:0] f_exp;
        logic              f_exp_en;
        logic [DATA_W-1:0] f_obs;
        logic              f_obs_en;
    } st_t;

    st_t st_d, st_q;

    logic              smp, last, miss;
    logic [ADDR_W-1:0] v_addr;
    logic [DATA_W-1:0] v_din, v_exp;
    ctl_t              v_ctl;

    mt_vec_timer #(.CYC_CLKS(CYC_CLKS), .SMP_CLKS(SMP_CLKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(st_q.busy), .smp(smp), .last(last)
    );

    mt_vec_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ITEM_W(ITEM_W)) u_dec (
        .phase(st_q.phase), .item(st_q.item), .sub(st_q.sub),
        .addr(v_addr), .din(v_din), .exp(v_exp), .ctl(v_ctl)
    );

    mt_rd_cmp #(.DATA_W(DATA_W)) u_cmp (
        .exp(v_exp), .exp_drv(v_ctl.exp_drv),
        .obs(mem_dout), .obs_drv(mem_dout_en), .miss(miss)
    );

    always_comb begin
        int n_items;
        n_items = is_walk(st_q.phase) ? N_ADDR : 1;
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.done  = 1'b0;
                st_d.fail  = 1'b0;
                st_d.phase = PH_INIT;
                st_d.item  = '0;
                st_d.sub   = '0;
                st_d.step  = '0;
            end
        end else if (smp && v_ctl.chk && miss) begin
            st_d.busy     = 1'b0;
            st_d.done     = 1'b1;
            st_d.fail     = 1'b1;
            st_d.f_step   = st_q.step;
            st_d.f_exp    = v_exp;
            st_d.f_exp_en = v_ctl.exp_drv;
            st_d.f_obs    = mem_dout;
            st_d.f_obs_en = mem_dout_en;
        end else if (last) begin
            st_d.step = st_q.step + 1'b1;
            if (st_q.sub == SUB_W'(vecs_in(st_q.phase) - 1)) begin
                st_d.sub = '0;
                if (st_q.item == ITEM_W'(n_items - 1)) begin
                    st_d.item = '0;
                    if (st_q.phase == PH_OE) begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase = phase_e'(st_q.phase + 3'd1);
                    end
                end else begin
                    st_d.item = st_q.item + 1'b1;
                end
            end else begin
                st_d.sub = st_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        mem_addr     = st_q.busy ? v_addr         : '0;
        mem_din      = st_q.busy ? v_din          : '0;
        mem_sel_hi   = st_q.busy ? v_ctl.sel_hi   : 1'b0;
        mem_sel_lo_n = st_q.busy ? v_ctl.sel_lo_n : 1'b1;
        mem_we_n     = st_q.busy ? v_ctl.we_n     : 1'b1;
        mem_oe_n     = st_q.busy ? v_ctl.oe_n     : 1'b1;
        busy         = st_q.busy;
        done         = st_q.done;
        fail         = st_q.fail;
        fail_step    = st_q.f_step;
        fail_exp     = st_q.f_exp;
        fail_exp_en  = st_q.f_exp_en;
        fail_obs     = st_q.f_obs;
        fail_obs_en  = st_q.f_obs_en;
    end

    a_r1_idle_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_we_n && mem_oe_n && !mem_sel_hi && mem_sel_lo_n));
    a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    a_r2_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    a_r8_one_select_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_sel_hi || !mem_sel_lo_n));
    a_r11_fail_means_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && !busy));
    a_r11_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_step) && $stable(fail_obs)));

endmodule

// File: tb/sim_mt_seq.sv
`timescale 1ns/1ps
module sim_mt_seq;
    localparam int CYC     = 500 / 5;
    localparam int SMP     = 400 / 5;
    localparam int NA      = 9;
    localparam int NSTEP   = 129;
    localparam int B_SWAP  = 1 + 3 * NA;
    localparam int B_VER   = B_SWAP + 5 * NA;
    localparam int B_SLO   = B_VER + 2 * NA;
    localparam int B_SHI   = B_SLO + 13;
    localparam int B_OE    = B_SHI + 13;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0] mem_dout, mem_din, fail_exp, fail_obs;
    logic mem_dout_en, mem_sel_hi, mem_sel_lo_n, mem_we_n, mem_oe_n;
    logic busy, done, fail, fail_exp_en, fail_obs_en;
    logic [7:0] mem_addr, fail_step;

    always #2.5 clk = ~clk;

    mt_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_addr(mem_addr), .mem_din(mem_din),
        .mem_sel_hi(mem_sel_hi), .mem_sel_lo_n(mem_sel_lo_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .busy(busy), .done(done), .fail(fail), .fail_step(fail_step),
        .fail_exp(fail_exp), .fail_exp_en(fail_exp_en),
        .fail_obs(fail_obs), .fail_obs_en(fail_obs_en)
    );

    // behavioural memory with one injectable fault
    // fk: 0 none, 1 address bit fa ignored, 2 data bit fa stuck at 0,
    //     3 low select ignored, 4 high select ignored, 5 output enable ignored
    int fk = 0, fa = 0;
    logic mem_clr = 1'b0;
    logic [3:0] mem [256];
    logic [7:0] a_eff;
    logic sel_ok, rd_en;
    logic [3:0] rd;

    always_comb begin
        a_eff  = (fk == 1) ? (mem_addr & ~(8'd1 << fa)) : mem_addr;
        sel_ok = (mem_sel_hi || fk == 4) && (!mem_sel_lo_n || fk == 3);
        rd_en  = sel_ok && mem_we_n && (!mem_oe_n || fk == 5);
        rd     = mem[a_eff];
        if (fk == 2) rd[fa] = 1'b0;
        mem_dout    = rd_en ? rd : 4'd0;
        mem_dout_en = rd_en;
    end

    always @(negedge clk) begin
        if (mem_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 4'd0;
        end else if (sel_ok && !mem_we_n) begin
            mem[a_eff] <= mem_din;
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0, t0 = 0, dcyc = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic launch();
        mem_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mem_clr = 1'b0;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        t0 = cyc;
    endtask

    task automatic finish_run();
        @(negedge clk);
        while (!done && cyc < t0 + (NSTEP + 10) * CYC) @(negedge clk);
        dcyc = cyc;
    endtask

    task automatic run_fault(input int k, input int a);
        fk = k;
        fa = a;
        launch();
        finish_run();
    endtask

    task automatic expect_fail(input string req, input int step, input int e,
                               input int e_en, input int o, input int o_en);
        check(done && fail, req, {done, fail}, 3);
        check(dcyc == t0 + step * CYC + SMP, req, dcyc - t0, step * CYC + SMP);
        check(int'(fail_step) == step, req, fail_step, step);
        check(int'(fail_exp) == e && int'(fail_exp_en) == e_en, req,
              {fail_exp_en, fail_exp}, e_en * 16 + e);
        check(int'(fail_obs) == o && int'(fail_obs_en) == o_en, req,
              {fail_obs_en, fail_obs}, o_en * 16 + o);
    endtask

    function automatic bit at_vec(input int v);
        return 1'b1;
    endfunction

    initial begin
        #950000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset and parked state
        check(!busy && !done && !fail, "R1", {busy, done, fail}, 0);
        check(mem_we_n && mem_oe_n && !mem_sel_hi && mem_sel_lo_n, "R1",
              {mem_we_n, mem_oe_n, mem_sel_hi, mem_sel_lo_n}, 4'b1101);

        // passing run with drive sequence checks
        fk = 0;
        launch();
        check(busy, "R2", busy, 1);
        wait_to(t0 + 0 * CYC + 50);
        check(mem_addr == 0 && mem_sel_hi && !mem_sel_lo_n && mem_we_n && !mem_oe_n
              && mem_din == 0, "R4",
              {mem_addr, mem_sel_hi, mem_sel_lo_n, mem_we_n, mem_oe_n}, 12'h00a);
        wait_to(t0 + 2 * CYC - 1);
        check(mem_we_n, "R3", mem_we_n, 1);
        wait_to(t0 + 2 * CYC);
        check(!mem_we_n && mem_din == 4'b0101 && mem_addr == 0, "R5",
              {mem_we_n, mem_din, mem_addr}, 13'h0500);
        wait_to(t0 + 3 * CYC + 50);
        check(mem_we_n, "R5", mem_we_n, 1);
        for (int i = 1; i < NA; i++) begin
            wait_to(t0 + (2 + 3 * i) * CYC + 50);
            check(!mem_we_n && int'(mem_addr) == (1 << (i - 1)), "R4",
                  mem_addr, 1 << (i - 1));
        end
        wait_to(t0 + (B_SWAP + 3) * CYC + 50);
        check(!mem_we_n && mem_din == 4'b1010, "R6", {mem_we_n, mem_din}, 5'h0a);
        wait_to(t0 + 50 * CYC + 10);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_to(t0 + (B_SLO + 6) * CYC + 50);
        check(mem_sel_lo_n && mem_sel_hi, "R8", {mem_sel_hi, mem_sel_lo_n}, 3);
        wait_to(t0 + (B_SLO + 8) * CYC + 50);
        check(!mem_we_n && mem_din == 4'hf, "R8", {mem_we_n, mem_din}, 5'h0f);
        wait_to(t0 + (B_SHI + 6) * CYC + 50);
        check(!mem_sel_hi && !mem_sel_lo_n, "R9", {mem_sel_hi, mem_sel_lo_n}, 0);
        wait_to(t0 + (B_OE + 6) * CYC + 50);
        check(mem_oe_n, "R10", mem_oe_n, 1);
        wait_to(t0 + NSTEP * CYC - 1);
        check(busy && !done, "R2", {busy, done}, 2);
        finish_run();
        check(dcyc == t0 + NSTEP * CYC, "R2", dcyc - t0, NSTEP * CYC);
        check(done && !fail && !busy, "R2", {done, fail, busy}, 4);

        // R6 address aliasing sweep
        for (int k = 0; k < 8; k++) begin
            run_fault(1, k);
            expect_fail("R6", B_SWAP + 1 + 5 * (k + 1), 5, 1, 10, 1);
        end
        // R7 / R6 stuck data bit sweep
        for (int b = 0; b < 4; b++) begin
            run_fault(2, b);
            if (((5 >> b) & 1) == 1) expect_fail("R6", B_SWAP + 1, 5, 1, 5 & ~(1 << b), 1);
            else                     expect_fail("R7", B_VER + 1, 10, 1, 10 & ~(1 << b), 1);
        end
        run_fault(3, 0);
        expect_fail("R8", B_SLO + 12, 0, 1, 15, 1);
        run_fault(4, 0);
        expect_fail("R9", B_SHI + 12, 0, 1, 15, 1);
        run_fault(5, 0);
        expect_fail("R10", B_OE + 11, 0, 0, 0, 1);

        // R11 values held while idle, R12 restart clears the failure
        repeat (30) @(negedge clk);
        check(fail && int'(fail_step) == B_OE + 11, "R11", fail_step, B_OE + 11);
        fk = 0;
        launch();
        check(!fail && !done && busy, "R12", {fail, done, busy}, 1);
        finish_run();
        check(done && !fail && dcyc == t0 + NSTEP * CYC, "R12", dcyc - t0, NSTEP * CYC);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule